// File: doc/BRIEF.md
# Non-Volatile Store Sequencer with Active-Low Busy Flag

This block runs the cycle that commits a wiper setting into non-volatile storage. It watches the serial frame through a frame-position input and a chip-select. It accepts a store command only when the program request was low at the start bit and is high at the clock edge right after the last data bit. When it accepts a command it latches the data word. It then drives an active-low ready/busy flag low and raises a busy-inhibit line. That line tells the serial interface to ignore incoming bits and keep its data output released.

The cycle is timed by counting edges of the serial clock, which must keep running, over a parameterised number of cycles. That number is chosen to cover the minimum programming time at the nominal clock rate. A supply-good input gates the operation. With a low supply at the command, the store is refused and the flag never drops. A supply drop or a falling program request during the cycle aborts it. The shadow register is written, with a one-cycle write strobe, only when the full count completes.

Top module: `nvstore_seq`

## Requirements
- R1: After reset, readyBusyN is 1, busyInhibit is 0, shadowWe is 0 and shadowQ holds INIT_VAL.
- R2: A store is accepted on a rising clock edge where chipSel is 1, framePos equals ACCEPT_POS (the edge after the last data bit), progReq is 1, supplyOk is 1, and progReq was 0 on the start-bit edge (framePos equal to 0) of the same selection. From the next cycle, readyBusyN is 0.
- R3: If progReq is already 1 on the start-bit edge, the command is not accepted and readyBusyN stays 1.
- R4: A progReq that rises only after the accept edge does not start a store.
- R5: After acceptance, readyBusyN stays low for exactly CYCLE_LEN clock cycles when progReq and supplyOk stay high throughout. busyInhibit is 1 in exactly those cycles.
- R6: At a completed cycle, shadowQ takes the stored value and shadowWe is 1 for exactly one cycle, the same cycle in which readyBusyN returns to 1.
- R7: The stored value is the dataWord sampled on the accept edge. Later changes on dataWord do not alter it.
- R8: If supplyOk is 0 on the accept edge, the store is refused: readyBusyN never drops and shadowQ is unchanged.
- R9: If progReq is 0 on any edge of the cycle, including the edge that would finish it, the cycle aborts. readyBusyN returns to 1 after that edge, shadowWe stays 0 and shadowQ is unchanged.
- R10: If supplyOk is 0 on any edge of the cycle, the cycle aborts with the same effects as R9.
- R11: chipSel at 0 on the accept edge, or at 0 on any edge between the start bit and the accept edge, prevents acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, free running during a store |
| rstN | input | 1 | Active-low asynchronous reset |
| chipSel | input | 1 | Frame select, active high |
| framePos | input | POS_W | Index of the bit taken on this edge (0 is the start bit) |
| progReq | input | 1 | Program request |
| supplyOk | input | 1 | Supply above programming minimum |
| dataWord | input | DATA_W | Wiper value held by the serial register |
| readyBusyN | output | 1 | Ready/busy flag, low while storing |
| busyInhibit | output | 1 | Tells the serial interface to ignore input and release output |
| shadowWe | output | 1 | One-cycle strobe when the shadow register is written |
| shadowQ | output | DATA_W | Shadow register contents |

## Verification
The bench builds the block with CYCLE_LEN set to 16 instead of the multi-millisecond default. This makes full cycles short enough to measure exactly, and it lets the bench drop the request on the very finishing edge (cycle 16) and one edge later (cycle 17). DATA_W 8, POS_W 4 and ACCEPT_POS 11 keep the default frame shape: one start bit, two address bits and eight data bits. With these values the bench can reach full stores, early aborts, supply refusals, the misplaced request edges, and a chip-select gap.

// File: rtl/nvstore_pkg.sv
package nvstore_pkg;

  // Strobes passed from the control FSM to the datapath
  typedef struct packed {
    logic accept;   // store command taken on this edge
    logic finish;   // cycle completes on this edge
  } nvsStrobe_t;

endpackage

// File: rtl/nvstore_ctrl.sv
module nvstore_ctrl
  import nvstore_pkg::*;
#(
  parameter int POS_W      = 4,
  parameter int ACCEPT_POS = 11,
  parameter int CYCLE_LEN  = 30000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic [POS_W-1:0] framePos,
  input  logic             progReq,
  input  logic             supplyOk,
  output logic             busy,
  output nvsStrobe_t       strobe
);

  localparam int CNT_W = (CYCLE_LEN > 2) ? $clog2(CYCLE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CYCLE_LEN - 1);
  localparam logic [POS_W-1:0] START_IDX = '0;
  localparam logic [POS_W-1:0] ACC_IDX   = POS_W'(ACCEPT_POS);

  logic             armed;
  logic [CNT_W-1:0] cycCnt;
  logic             acceptNow;
  logic             keepGoing;
  logic             finishNow;

  always_comb begin
    acceptNow = chipSel && (framePos == ACC_IDX) && armed &&
                progReq && supplyOk && !busy;
    keepGoing = progReq && supplyOk;
    finishNow = busy && keepGoing && (cycCnt == LAST_CNT);
    strobe.accept = acceptNow;
    strobe.finish = finishNow;
  end

  // Arming: request must be low at the start bit of the current selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (!chipSel) begin
      armed <= 1'b0;
    end else if (framePos == START_IDX) begin
      armed <= !progReq;
    end else if (acceptNow) begin
      armed <= 1'b0;
    end
  end

  // Cycle timer on the running serial clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cycCnt <= '0;
    end else if (acceptNow) begin
      busy   <= 1'b1;
      cycCnt <= '0;
    end else if (busy) begin
      if (!keepGoing || finishNow) begin
        busy <= 1'b0;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

  // R2: busy only starts right after a qualified accept edge
  p_start_qualified_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(chipSel && progReq && supplyOk && (framePos == ACC_IDX)));

  // R8: no cycle starts while supply is low
  p_refuse_low_supply_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !supplyOk) |=> !busy);

  // R9: request falling ends the cycle
  p_abort_on_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !progReq) |=> !busy);

  // R10: supply loss ends the cycle
  p_abort_on_supply_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !supplyOk) |=> !busy);

  // R5: timer never runs past the cycle length
  p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cycCnt <= LAST_CNT));

endmodule

// File: rtl/nvstore_dpath.sv
module nvstore_dpath
  import nvstore_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvsStrobe_t        strobe,
  input  logic [DATA_W-1:0] dataWord,
  output logic              shadowWe,
  output logic [DATA_W-1:0] shadowQ
);

  logic [DATA_W-1:0] pendWord;

  // Capture the word at the accept edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord <= '0;
    end else if (strobe.accept) begin
      pendWord <= dataWord;
    end
  end

  // Commit only on a completed cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ  <= INIT_VAL;
      shadowWe <= 1'b0;
    end else begin
      shadowWe <= strobe.finish;
      if (strobe.finish) begin
        shadowQ <= pendWord;
      end
    end
  end

  // R6: shadow changes only together with its write strobe
  p_shadow_guarded_r6: assert property (@(posedge clk) disable iff (!rstN)
    !shadowWe |-> $stable(shadowQ));

  // R6: write strobe lasts a single cycle
  p_we_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    shadowWe |=> !shadowWe);

endmodule

// File: rtl/nvstore_seq.sv
module nvstore_seq
  import nvstore_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter int               POS_W      = 4,
  parameter int               ACCEPT_POS = 11,
  parameter int               CYCLE_LEN  = 30000,
  parameter logic [DATA_W-1:0] INIT_VAL  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic [POS_W-1:0]  framePos,
  input  logic              progReq,
  input  logic              supplyOk,
  input  logic [DATA_W-1:0] dataWord,
  output logic              readyBusyN,
  output logic              busyInhibit,
  output logic              shadowWe,
  output logic [DATA_W-1:0] shadowQ
);

  nvsStrobe_t strobe;
  logic       busy;

  nvstore_ctrl #(
    .POS_W      (POS_W),
    .ACCEPT_POS (ACCEPT_POS),
    .CYCLE_LEN  (CYCLE_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSel  (chipSel),
    .framePos (framePos),
    .progReq  (progReq),
    .supplyOk (supplyOk),
    .busy     (busy),
    .strobe   (strobe)
  );

  nvstore_dpath #(
    .DATA_W   (DATA_W),
    .INIT_VAL (INIT_VAL)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataWord (dataWord),
    .shadowWe (shadowWe),
    .shadowQ  (shadowQ)
  );

  assign readyBusyN  = !busy;
  assign busyInhibit = busy;

  // R6: a write only ends a cycle that was running
  p_write_after_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    shadowWe |-> ($past(busyInhibit) && readyBusyN));

endmodule

// File: tb/nvstore_seq_tb.sv
module nvstore_seq_tb;

  localparam int LEN  = 16;
  localparam int NONE = 40;

  logic       clk = 1'b0;
  logic       rstN;
  logic       chipSel;
  logic [3:0] framePos;
  logic       progReq;
  logic       supplyOk;
  logic [7:0] dataWord;
  logic       readyBusyN;
  logic       busyInhibit;
  logic       shadowWe;
  logic [7:0] shadowQ;

  int checks = 0;
  int errors = 0;
  logic [7:0] expShadow;

  always #5 clk = ~clk;

  nvstore_seq #(
    .DATA_W(8), .POS_W(4), .ACCEPT_POS(11), .CYCLE_LEN(LEN), .INIT_VAL(8'h80)
  ) u_dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .framePos(framePos),
    .progReq(progReq), .supplyOk(supplyOk), .dataWord(dataWord),
    .readyBusyN(readyBusyN), .busyInhibit(busyInhibit),
    .shadowWe(shadowWe), .shadowQ(shadowQ)
  );

  typedef struct packed {
    logic       csAcc;
    logic       progStart;
    logic       progAcc;
    logic       supAcc;
    logic [7:0] progDrop;
    logic [7:0] supDrop;
    logic [7:0] data;
    logic [7:0] expBusy;
    logic       expWr;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'(NONE), 8'(NONE), 8'hA5, 8'(LEN), 1'b1}, // R2 R5 R6 R7
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'(NONE), 8'(NONE), 8'h3C, 8'd0,   1'b0}, // R8
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'(NONE), 8'(NONE), 8'h11, 8'd0,   1'b0}, // R3
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'(NONE), 8'(NONE), 8'h22, 8'd0,   1'b0}, // R4
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'd5,     8'(NONE), 8'h77, 8'd5,   1'b0}, // R9
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'(NONE), 8'd9,     8'hE1, 8'd9,   1'b0}, // R10
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'(NONE), 8'(NONE), 8'h5A, 8'd0,   1'b0}, // R11
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'(NONE), 8'(NONE), 8'h0F, 8'(LEN), 1'b1}, // R5 R6
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'(LEN),  8'(NONE), 8'h99, 8'(LEN), 1'b0}, // R9 boundary
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'(LEN+1), 8'(NONE), 8'hC3, 8'(LEN), 1'b1} // R2 minimum met
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one frame: positions 0..11, accept edge at position 11
  task automatic frame(input logic csAcc, input logic ps, input logic pa,
                       input logic sup, input logic [7:0] data, input bit csGap);
    for (int pos = 0; pos < 12; pos++) begin
      @(negedge clk);
      framePos = 4'(pos);
      chipSel  = (pos == 11) ? csAcc : !(csGap && pos == 5);
      progReq  = (pos == 0) ? ps : pa;
      supplyOk = (pos == 11) ? sup : 1'b1;
      dataWord = data;
      @(posedge clk);
    end
  endtask

  // Observe the cycle after the accept edge
  task automatic observe(input int pDrop, input int sDrop, input logic [7:0] data,
                         output int busyCnt, output int inhCnt, output int weCnt,
                         output bit weAligned);
    busyCnt = 0; inhCnt = 0; weCnt = 0; weAligned = 1'b1;
    for (int i = 1; i <= LEN + 3; i++) begin
      @(negedge clk);
      if (!readyBusyN) busyCnt++;
      if (busyInhibit) inhCnt++;
      if (shadowWe) begin
        weCnt++;
        if (!readyBusyN) weAligned = 1'b0;
      end
      chipSel  = 1'b0;
      framePos = '0;
      progReq  = (i < pDrop);
      supplyOk = (i < sDrop);
      dataWord = ~data;
    end
    progReq  = 1'b0;
    supplyOk = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; chipSel = 1'b0; framePos = '0; progReq = 1'b0;
    supplyOk = 1'b1; dataWord = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(readyBusyN == 1'b1, "R1 readyBusyN", int'(readyBusyN), 1);
    check(busyInhibit == 1'b0, "R1 busyInhibit", int'(busyInhibit), 0);
    check(shadowWe == 1'b0, "R1 shadowWe", int'(shadowWe), 0);
    check(shadowQ == 8'h80, "R1 shadowQ", int'(shadowQ), 'h80);
    rstN = 1'b1;
    expShadow = 8'h80;

    foreach (VECS[k]) begin
      int b, n, w;
      bit al;
      frame(VECS[k].csAcc, VECS[k].progStart, VECS[k].progAcc, VECS[k].supAcc,
            VECS[k].data, 1'b0);
      observe(int'(VECS[k].progDrop), int'(VECS[k].supDrop), VECS[k].data, b, n, w, al);
      if (VECS[k].expWr) expShadow = VECS[k].data;
      check(b == int'(VECS[k].expBusy), $sformatf("R5/R9/R10 busy cycles vec%0d", k), b, int'(VECS[k].expBusy));
      check(n == b, $sformatf("R5 inhibit cycles vec%0d", k), n, b);
      check(w == int'(VECS[k].expWr), $sformatf("R6 write strobes vec%0d", k), w, int'(VECS[k].expWr));
      check(al, $sformatf("R6 strobe with ready vec%0d", k), int'(al), 1);
      check(shadowQ == expShadow, $sformatf("R7/R8 shadow vec%0d", k), int'(shadowQ), int'(expShadow));
    end

    // R11: chip-select gap between start bit and accept edge clears arming
    begin
      int b, n, w;
      bit al;
      frame(1'b1, 1'b0, 1'b1, 1'b1, 8'h6B, 1'b1);
      observe(NONE, NONE, 8'h6B, b, n, w, al);
      check(b == 0, "R11 gap busy cycles", b, 0);
      check(w == 0, "R11 gap write strobes", w, 0);
      check(shadowQ == expShadow, "R11 gap shadow", int'(shadowQ), int'(expShadow));
    end

    // R2: a fresh frame after the gap is accepted again
    begin
      int b, n, w;
      bit al;
      frame(1'b1, 1'b0, 1'b1, 1'b1, 8'h3E, 1'b0);
      observe(NONE, NONE, 8'h3E, b, n, w, al);
      check(b == LEN, "R2 re-accept busy cycles", b, LEN);
      check(shadowQ == 8'h3E, "R7 re-accept shadow", int'(shadowQ), 'h3E);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule